// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder for Three-Phase Motors

This block converts the three rotor-position bits of a brushless motor into six gate enables for a three-phase bridge, three for the high-side switches and three for the low-side switches. Each valid position selects one phase to source current and a different phase to sink it. A direction request swaps the two roles, so the same position code drives the motor the other way.

Several commands can override the normal drive. Undervoltage lockout and coast switch every output off. Brake switches off all high-side outputs and turns on all low-side outputs. A cycle-level PWM latch chops the drive. The latch is set at the start of each switching cycle. A PWM-comparator trip or an overcurrent trip clears it, which limits current pulse by pulse. A quadrant-mode select decides which switches the latch chops: the low-side switches only, or both the high-side and low-side switches.

The Hall bits pass through a two-stage synchronizer and a stability filter. All six outputs come from registers, so every change happens on a single clock edge.

Top module: `bldc_commutator`

## Requirements
- R1: While `rst_n` is low, all six enables are 0 and the PWM latch is clear. After release, the outputs stay 0 until a cycle-start strobe sets the latch.
- R2: With `dir_req`=1, the filtered code `hall_in`[2:0] (bit 2 = phase A, bit 1 = B, bit 0 = C; the enable vectors use the same bit order) selects the phase pair (high, low) as follows: 101→(A,B), 100→(A,C), 110→(B,C), 010→(B,A), 011→(C,A), 001→(C,B).
- R3: With `dir_req`=0, every code of R2 selects the same two phases with the high and low roles swapped.
- R4: With brake, coast and undervoltage all low, the filtered codes 000 and 111 switch all six enables off.
- R5: Whenever `coast` or `uv_lock` is high at a clock edge, all six enables are 0 after that edge, whatever the other inputs are.
- R6: When `brake` is high and neither coast nor undervoltage is active, `hi_en` is 000 and `lo_en` is 111 gated by the PWM latch. This holds for any Hall code, including 000 and 111.
- R7: With `quad_sel`=0, only the active low-side enable is gated by the PWM latch and the high-side enable stays on. With `quad_sel`=1, both active enables are gated.
- R8: At each edge, the PWM latch clears if `pwm_trip` or `oc_trip` is high. Otherwise it sets if `cyc_start` is high, and otherwise it holds. A trip that arrives together with the strobe keeps the latch clear. With no trip, the drive stays on for the whole cycle (100 percent duty).
- R9: The Hall code passes two synchronizer flops. The decoded position then updates only after the synchronized code has held one value for HALL_STABLE_CYCLES consecutive clocks. Shorter glitches leave the outputs unchanged.
- R10: The enables are registered. The PWM latch and the brake, coast, undervoltage and mode inputs act on the outputs at the same edge at which they are sampled. A high-side and a low-side enable of the same phase are never both on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Raw Hall position bits, bit 2 = phase A |
| dir_req | input | 1 | Requested rotation direction |
| brake | input | 1 | Brake command |
| coast | input | 1 | Coast command, all outputs off |
| quad_sel | input | 1 | 0: chop low side only, 1: chop both sides |
| pwm_trip | input | 1 | PWM comparator trip, clears the latch |
| oc_trip | input | 1 | Overcurrent trip, clears the latch |
| uv_lock | input | 1 | Undervoltage lockout flag |
| cyc_start | input | 1 | Switching-cycle start strobe, sets the latch |
| hi_en | output | 3 | High-side gate enables, bit 2 = phase A |
| lo_en | output | 3 | Low-side gate enables, bit 2 = phase A |

## Verification
The bench builds the block with HALL_STABLE_CYCLES set to 3. A glitch of two clocks can then be shown to be rejected, while a hold of three clocks is accepted, and both fit within a few cycles of rotation. The cycle-start strobe repeats every ten clocks. This period is short enough that trips arriving mid-cycle, a trip that coincides with the strobe, and full-duty cycles without any trip all occur under each direction and quadrant mode. The same holds under brake combined with invalid codes.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  typedef logic [2:0] phase_vec_t;

  localparam phase_vec_t PH_A    = 3'b100;
  localparam phase_vec_t PH_B    = 3'b010;
  localparam phase_vec_t PH_C    = 3'b001;
  localparam phase_vec_t PH_NONE = 3'b000;
  localparam phase_vec_t PH_ALL  = 3'b111;

  typedef struct packed {
    logic       valid;
    phase_vec_t src;
    phase_vec_t snk;
  } drive_pair_t;
endpackage

// File: rtl/hall_qualifier.sv
module hall_qualifier #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_raw,
  output logic [2:0] hall_q
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STABLE_CYCLES);

  logic [2:0]    sync1_q, sync2_q, cand_q, cand_d, state_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    cand_d  = cand_q;
    run_d   = run_q;
    state_d = hall_q;
    if (sync2_q == cand_q && run_q != '0) begin
      if (run_q != RUN_MAX) run_d = run_q + 1'b1;
    end else begin
      cand_d = sync2_q;
      run_d  = CW'(1);
    end
    if (run_d == RUN_MAX) state_d = sync2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      cand_q  <= '0;
      run_q   <= '0;
      hall_q  <= '0;
    end else begin
      sync1_q <= hall_raw;
      sync2_q <= sync1_q;
      cand_q  <= cand_d;
      run_q   <= run_d;
      hall_q  <= state_d;
    end
  end
endmodule

// File: rtl/pwm_gate_latch.sv
module pwm_gate_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic pwm_trip,
  input  logic oc_trip,
  output logic gate_next
);
  logic gate_q;

  always_comb begin
    if (pwm_trip || oc_trip) gate_next = 1'b0;
    else if (cyc_start)      gate_next = 1'b1;
    else                     gate_next = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_next;
  end
endmodule

// File: rtl/commutation_decode.sv
module commutation_decode
  import bldc_pkg::*;
(
  input  logic [2:0]  code,
  input  logic        fwd,
  output drive_pair_t pair
);
  phase_vec_t p_hi, p_lo;
  logic       ok;

  always_comb begin
    ok   = 1'b1;
    p_hi = PH_NONE;
    p_lo = PH_NONE;
    unique case (code)
      3'b101: begin p_hi = PH_A; p_lo = PH_B; end
      3'b100: begin p_hi = PH_A; p_lo = PH_C; end
      3'b110: begin p_hi = PH_B; p_lo = PH_C; end
      3'b010: begin p_hi = PH_B; p_lo = PH_A; end
      3'b011: begin p_hi = PH_C; p_lo = PH_A; end
      3'b001: begin p_hi = PH_C; p_lo = PH_B; end
      default: ok = 1'b0;
    endcase
    pair.valid = ok;
    pair.src   = fwd ? p_hi : p_lo;
    pair.snk   = fwd ? p_lo : p_hi;
  end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int HALL_STABLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_req,
  input  logic       brake,
  input  logic       coast,
  input  logic       quad_sel,
  input  logic       pwm_trip,
  input  logic       oc_trip,
  input  logic       uv_lock,
  input  logic       cyc_start,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);
  logic [2:0]  hall_pos;
  logic        gate;
  drive_pair_t pair;
  phase_vec_t  hi_d, lo_d, gate_v;

  hall_qualifier #(.STABLE_CYCLES(HALL_STABLE_CYCLES)) u_hall (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_in), .hall_q(hall_pos)
  );

  pwm_gate_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .pwm_trip(pwm_trip), .oc_trip(oc_trip), .gate_next(gate)
  );

  commutation_decode u_dec (
    .code(hall_pos), .fwd(dir_req), .pair(pair)
  );

  always_comb begin
    gate_v = {3{gate}};
    hi_d   = PH_NONE;
    lo_d   = PH_NONE;
    if (uv_lock || coast) begin
      hi_d = PH_NONE;
      lo_d = PH_NONE;
    end else if (brake) begin
      lo_d = PH_ALL & gate_v;
    end else if (pair.valid) begin
      hi_d = quad_sel ? (pair.src & gate_v) : pair.src;
      lo_d = pair.snk & gate_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en <= '0;
      lo_en <= '0;
    end else begin
      hi_en <= hi_d;
      lo_en <= lo_d;
    end
  end
endmodule

// File: rtl/bldc_commutator_checker.sv
module bldc_commutator_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       brake,
  input logic       coast,
  input logic       uv_lock,
  input logic       pwm_trip,
  input logic       oc_trip,
  input logic [2:0] hi_en,
  input logic [2:0] lo_en
);
  a_r5_coast_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (coast || uv_lock) |=> (hi_en == 3'b000 && lo_en == 3'b000));

  a_r6_brake_high_off: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> (hi_en == 3'b000));

  a_r8_trip_kills_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_trip || oc_trip) |=> (lo_en == 3'b000));

  a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == 3'b000);

  a_r2_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_en));
endmodule

bind bldc_commutator bldc_commutator_checker u_chk (
  .clk(clk), .rst_n(rst_n), .brake(brake), .coast(coast), .uv_lock(uv_lock),
  .pwm_trip(pwm_trip), .oc_trip(oc_trip), .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/bldc_commutator_bench.sv
`timescale 1ns/1ps
module bldc_commutator_bench;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic dir_req = 1'b1, brake = 1'b0, coast = 1'b0, quad_sel = 1'b0;
  logic pwm_trip = 1'b0, oc_trip = 1'b0, uv_lock = 1'b0, cyc_start = 1'b0;
  logic strobe_en = 1'b0;
  logic [2:0] hi_en, lo_en;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bldc_commutator #(.HALL_STABLE_CYCLES(N)) u_bldc_commutator (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_req(dir_req),
    .brake(brake), .coast(coast), .quad_sel(quad_sel), .pwm_trip(pwm_trip),
    .oc_trip(oc_trip), .uv_lock(uv_lock), .cyc_start(cyc_start),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  // reference model state
  int m_s1, m_s2, m_last, m_run, m_state;
  bit m_gate;
  logic [2:0] e_hi, e_lo;
  string tag;

  function automatic void pair_of(input int code, input bit fwd,
                                  output logic [2:0] h, output logic [2:0] l,
                                  output bit ok);
    logic [2:0] a, b;
    ok = 1;
    case (code)
      5: begin a = 3'b100; b = 3'b010; end
      4: begin a = 3'b100; b = 3'b001; end
      6: begin a = 3'b010; b = 3'b001; end
      2: begin a = 3'b010; b = 3'b100; end
      3: begin a = 3'b001; b = 3'b100; end
      1: begin a = 3'b001; b = 3'b010; end
      default: begin a = 0; b = 0; ok = 0; end
    endcase
    h = fwd ? a : b;
    l = fwd ? b : a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_last = 0; m_run = 0; m_state = 0; m_gate = 0;
      e_hi = 0; e_lo = 0; tag = "R1";
    end else begin
      logic [2:0] h, l;
      bit ok;
      if (pwm_trip || oc_trip) m_gate = 0;
      else if (cyc_start) m_gate = 1;
      pair_of(m_state, dir_req, h, l, ok);
      if (uv_lock || coast) begin e_hi = 0; e_lo = 0; tag = "R5"; end
      else if (brake) begin e_hi = 0; e_lo = m_gate ? 3'b111 : 3'b000; tag = "R6"; end
      else if (!ok) begin e_hi = 0; e_lo = 0; tag = "R4"; end
      else begin
        e_hi = (quad_sel && !m_gate) ? 3'b000 : h;
        e_lo = m_gate ? l : 3'b000;
        tag = !m_gate ? "R8" : quad_sel ? "R7" : dir_req ? "R2" : "R3";
      end
      if (m_run > 0 && m_s2 == m_last) begin
        if (m_run < N) m_run++;
      end else begin
        m_last = m_s2; m_run = 1;
      end
      if (m_run == N) m_state = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(hall_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (hi_en !== e_hi || lo_en !== e_lo) begin
        errors++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hi_en, lo_en, e_hi, e_lo);
      end
      checks++;
      if ((hi_en & lo_en) !== 3'b000) begin // R10
        errors++;
        $display("FAIL R10: hi=%b lo=%b expected no common phase", hi_en, lo_en);
      end
    end
  end

  // cycle-start strobe every ten clocks
  int sc = 0;
  always @(negedge clk) begin
    sc = (sc == 9) ? 0 : sc + 1;
    cyc_start <= strobe_en && (sc == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rotate(input bit fwd, input int hold);
    int seq[6] = '{5, 4, 6, 2, 3, 1};
    for (int i = 0; i < 6; i++) begin
      hall_in = 3'(fwd ? seq[i] : seq[5 - i]);
      if (i == 3) begin pwm_trip = 1; wait_n(1); pwm_trip = 0; wait_n(hold - 1); end
      else wait_n(hold);
    end
  endtask

  initial begin
    logic [2:0] sh, sl;
    wait_n(3);
    checks++; // R1 reset state
    if (hi_en !== 0 || lo_en !== 0) begin
      errors++; $display("FAIL R1: hi=%b lo=%b expected 000 000", hi_en, lo_en);
    end
    rst_n = 1;
    strobe_en = 1;
    hall_in = 3'b101;
    wait_n(12);
    // R2, R3 and R7/R8 across modes
    dir_req = 1; quad_sel = 0; rotate(1, 12);
    quad_sel = 1; rotate(1, 12);
    dir_req = 0; rotate(0, 12);
    quad_sel = 0; rotate(0, 12);
    dir_req = 1;
    // R8: overcurrent trip coinciding with strobe
    wait_n(20);
    @(negedge clk); while (sc != 9) @(negedge clk);
    oc_trip = 1; wait_n(2); oc_trip = 0; wait_n(25);
    // R4: invalid codes
    hall_in = 3'b000; wait_n(10);
    hall_in = 3'b111; wait_n(10);
    // R6: brake with invalid and valid codes, and with trip
    brake = 1; wait_n(12); hall_in = 3'b110; wait_n(12);
    oc_trip = 1; wait_n(1); oc_trip = 0; wait_n(12);
    // R5: coast and undervoltage dominate brake
    coast = 1; wait_n(6); coast = 0; uv_lock = 1; wait_n(6);
    brake = 0; wait_n(6); uv_lock = 0; coast = 1; wait_n(6); coast = 0;
    // R9: short glitch rejected
    hall_in = 3'b101; wait_n(30);
    sh = hi_en; sl = lo_en;
    hall_in = 3'b100; wait_n(2); hall_in = 3'b101;
    for (int k = 0; k < 8; k++) begin
      wait_n(1);
      checks++;
      if (hi_en !== sh || lo_en !== sl) begin
        errors++;
        $display("FAIL R9: hi=%b lo=%b expected hi=%b lo=%b", hi_en, lo_en, sh, sl);
      end
    end
    // R9: hold of exactly N accepted
    hall_in = 3'b100; wait_n(N); hall_in = 3'b110; wait_n(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule